// File: doc/BRIEF.md
# Two-Way Read Cache with Per-Set Way Prediction

This block is a two-way set-associative read cache. Each set holds one prediction bit that names the way expected to hit next. On a lookup the data multiplexer is steered by that bit at the same moment the tags are read, so the guessed way's word is already on its way to the output before the tag compare has resolved. A correct guess answers in the cycle after acceptance. A wrong guess, where the other way holds the line, takes exactly one extra cycle and retrains the set's bit to the way that really hit.

When neither way holds the line, the block answers with a miss, raises a refill request carrying the line address, and stalls until the next level supplies the whole line on the refill port. The line goes into an invalid way if the set has one, otherwise into the way not currently predicted, and the prediction then points at the newly filled way. Every response carries a flag saying whether it took the fast or the slow path, so mispredictions can be counted from outside.

Top module: `wpcache_top`

## Requirements
- R1: After reset rsp_valid and refill_req are 0, req_ready is 1, no line is valid and every set predicts way 0.
- R2: req_addr is a word address: the low log2(WORDS) bits select the word in the line, the next log2(SETS) bits select the set (line address modulo SETS), the remaining upper bits are the tag.
- R3: A request that hits in the predicted way is answered in the cycle after acceptance with rsp_hit=1, rsp_slow=0 and the addressed word.
- R4: A request that hits only in the other way gives no response in the cycle after acceptance, holds req_ready low for that cycle, and responds one cycle later with rsp_hit=1, rsp_slow=1 and the addressed word.
- R5: After a slow-path hit the set's prediction names the way that hit, so the next access to that line takes the fast path.
- R6: A request that hits in neither way is answered in the cycle after acceptance with rsp_hit=0, rsp_slow=0, rsp_data=0, and refill_req rises with refill_addr equal to req_addr shifted right by log2(WORDS).
- R7: While refill_req is high, req_ready is low, refill_addr is stable and requests are ignored (no response) until refill_valid is seen.
- R8: A refill writes way 0 if it is invalid, else way 1 if it is invalid, else the way not predicted.
- R9: After a refill the set predicts the refilled way, so the next access to that line takes the fast path.
- R10: In refill_data, word w of the line occupies bits [w*DATA_W +: DATA_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | ADDR_W | Word address of the read |
| req_ready | output | 1 | Request accepted this cycle when high |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Response is a hit |
| rsp_slow | output | 1 | Response took the one-cycle-later path |
| rsp_data | output | DATA_W | Read word (zero on a miss) |
| refill_req | output | 1 | Line fetch wanted |
| refill_addr | output | ADDR_W-log2(WORDS) | Line address to fetch |
| refill_valid | input | 1 | Whole line presented on refill_data |
| refill_data | input | WORDS*DATA_W | Line contents |

## Verification
The bench drives three lines that share one set so that every victim rule is reached: an empty way 0, an empty way 1, and a full set where the unpredicted way must be evicted; a design that evicted the predicted way would turn the following fast hit into a miss. It alternates between resident lines to force slow-path hits and then repeats them, so a design that failed to retrain would keep answering slow, and one that answered the slow path in the first cycle would show a response where none is due. During a pending refill it holds other requests on the input; a design that accepted them would produce a stray response. All word offsets of a filled line are read back, catching a swapped word order in the refill bus or a wrong address split.

// File: rtl/wpc_pkg.sv
// Shared types for the way-predicted cache.
// Assumes: a single outstanding lookup at a time.
package wpc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SLOW = 2'd1,
        ST_FILL = 2'd2
    } wpc_state_e;
endpackage

// File: rtl/wpc_way.sv
// One way of the cache: valid bits, tags and line storage, read
// combinationally at rd_idx, written with a whole line on wr_en.
// Assumes the caller never writes and reads different sets in a way
// that relies on write-then-read in the same cycle.
module wpc_way #(
    parameter int SETS   = 16,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 10,
    localparam int IDX_W = $clog2(SETS),
    localparam int OFF_W = $clog2(WORDS),
    localparam int LINE_W = WORDS * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic [OFF_W-1:0]  rd_off,
    output logic              hit,
    output logic              vld,
    output logic [DATA_W-1:0] word,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_line
);
    logic [SETS-1:0]   valid_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [LINE_W-1:0] line_q [SETS];

    // Valid bits: cleared on reset, set when a line is written.
    always_ff @(posedge clk) begin
        if (!rst_n)
            valid_q <= '0;
        else if (wr_en)
            valid_q[wr_idx] <= 1'b1;
    end

    // Tag and data arrays: written whole-line on refill.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            line_q[wr_idx] <= wr_line;
        end
    end

    // Read port: validity, tag compare and word select.
    always_comb begin
        vld  = valid_q[rd_idx];
        hit  = vld && (tag_q[rd_idx] == rd_tag);
        word = line_q[rd_idx][rd_off*DATA_W +: DATA_W];
    end
endmodule

// File: rtl/wpc_pred.sv
// Per-set way prediction bits; every set points at way 0 after reset.
// Assumes two ways, so one bit per set.
module wpc_pred #(
    parameter int SETS = 16,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    output logic             pred_way,
    input  logic             we,
    input  logic             wdata
);
    logic [SETS-1:0] bits_q;

    // Prediction storage: reset to way 0, retrained on write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bits_q <= '0;
        else if (we)
            bits_q[idx] <= wdata;
    end

    // Read of the looked-up set's prediction.
    assign pred_way = bits_q[idx];
endmodule

// File: rtl/wpc_ctrl.sv
// Lookup sequencer: answers fast on a predicted hit, spends one extra
// cycle on an unpredicted hit, and stalls for a refill on a miss.
// Assumes hit[0] and hit[1] are never both high.
module wpc_ctrl #(
    parameter int ADDR_W = 16,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [ADDR_W-1:0]      req_addr,
    output logic                   req_ready,
    output logic [ADDR_W-1:0]      cap_addr,
    output logic                   look_cap,
    input  logic [1:0]             hit,
    input  logic [1:0]             vld,
    input  logic                   pred_way,
    input  logic [DATA_W-1:0]      fast_word,
    input  logic [DATA_W-1:0]      alt_word,
    output logic                   pred_we,
    output logic                   pred_wdata,
    output logic                   fill_we,
    output logic                   fill_way,
    input  logic                   refill_valid,
    output logic                   refill_req,
    output logic [ADDR_W-OFF_W-1:0] refill_addr,
    output logic                   rsp_valid,
    output logic                   rsp_hit,
    output logic                   rsp_slow,
    output logic [DATA_W-1:0]      rsp_data
);
    import wpc_pkg::*;

    wpc_state_e        state_q;
    logic [DATA_W-1:0] slow_q;
    logic              acc, alt_way, fast_hit, alt_hit;

    // Decode of the current lookup and refill decisions.
    always_comb begin
        alt_way    = ~pred_way;
        acc        = (state_q == ST_IDLE) && req_valid;
        fast_hit   = hit[pred_way];
        alt_hit    = hit[alt_way];
        req_ready  = (state_q == ST_IDLE);
        look_cap   = (state_q != ST_IDLE);
        refill_req = (state_q == ST_FILL);
        refill_addr = cap_addr[ADDR_W-1:OFF_W];
        fill_we    = (state_q == ST_FILL) && refill_valid;
        if (!vld[0])
            fill_way = 1'b0;
        else if (!vld[1])
            fill_way = 1'b1;
        else
            fill_way = alt_way;
        pred_we    = (acc && !fast_hit && alt_hit) || fill_we;
        pred_wdata = fill_we ? fill_way : alt_way;
    end

    // State, captured address and registered response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cap_addr  <= '0;
            slow_q    <= '0;
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_slow  <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_slow  <= 1'b0;
            rsp_data  <= '0;
            unique case (state_q)
                ST_IDLE: if (acc) begin
                    cap_addr <= req_addr;
                    if (fast_hit) begin
                        rsp_valid <= 1'b1;
                        rsp_hit   <= 1'b1;
                        rsp_data  <= fast_word;
                    end else if (alt_hit) begin
                        slow_q  <= alt_word;
                        state_q <= ST_SLOW;
                    end else begin
                        rsp_valid <= 1'b1;
                        state_q   <= ST_FILL;
                    end
                end
                ST_SLOW: begin
                    rsp_valid <= 1'b1;
                    rsp_hit   <= 1'b1;
                    rsp_slow  <= 1'b1;
                    rsp_data  <= slow_q;
                    state_q   <= ST_IDLE;
                end
                ST_FILL: if (refill_valid) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wpcache_top.sv
// Two-way read cache with per-set way prediction. The output word is
// selected by the stored prediction in parallel with the tag compare.
// Assumes the refill port delivers the line named by refill_addr.
module wpcache_top #(
    parameter int ADDR_W = 16,
    parameter int SETS   = 16,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W  = $clog2(SETS),
    localparam int OFF_W  = $clog2(WORDS),
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
    localparam int LINE_W = WORDS * DATA_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [ADDR_W-1:0]       req_addr,
    output logic                    req_ready,
    output logic                    rsp_valid,
    output logic                    rsp_hit,
    output logic                    rsp_slow,
    output logic [DATA_W-1:0]       rsp_data,
    output logic                    refill_req,
    output logic [ADDR_W-OFF_W-1:0] refill_addr,
    input  logic                    refill_valid,
    input  logic [LINE_W-1:0]       refill_data
);
    logic [ADDR_W-1:0] cap_addr, look_addr;
    logic              look_cap;
    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;
    logic [OFF_W-1:0]  off;
    logic [1:0]        hit, vld;
    logic [DATA_W-1:0] word [2];
    logic              pred_way, pred_we, pred_wdata, fill_we, fill_way;
    logic [DATA_W-1:0] fast_word, alt_word;

    // Address split: word offset low, set index next, tag on top.
    always_comb begin
        look_addr = look_cap ? cap_addr : req_addr;
        off = look_addr[OFF_W-1:0];
        idx = look_addr[OFF_W +: IDX_W];
        tag = look_addr[ADDR_W-1 -: TAG_W];
    end

    for (genvar g = 0; g < 2; g++) begin : g_way
        wpc_way #(.SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_way (
            .clk(clk), .rst_n(rst_n),
            .rd_idx(idx), .rd_tag(tag), .rd_off(off),
            .hit(hit[g]), .vld(vld[g]), .word(word[g]),
            .wr_en(fill_we && (fill_way == g[0])),
            .wr_idx(idx), .wr_tag(tag), .wr_line(refill_data)
        );
    end

    wpc_pred #(.SETS(SETS)) u_pred (
        .clk(clk), .rst_n(rst_n), .idx(idx), .pred_way(pred_way),
        .we(pred_we), .wdata(pred_wdata)
    );

    // Data steering by prediction, independent of the tag compare.
    always_comb begin
        fast_word = word[pred_way];
        alt_word  = word[~pred_way];
    end

    wpc_ctrl #(.ADDR_W(ADDR_W), .WORDS(WORDS), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .cap_addr(cap_addr), .look_cap(look_cap),
        .hit(hit), .vld(vld), .pred_way(pred_way),
        .fast_word(fast_word), .alt_word(alt_word),
        .pred_we(pred_we), .pred_wdata(pred_wdata),
        .fill_we(fill_we), .fill_way(fill_way),
        .refill_valid(refill_valid), .refill_req(refill_req),
        .refill_addr(refill_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_slow(rsp_slow),
        .rsp_data(rsp_data)
    );
endmodule

// File: rtl/wpc_chk.sv
// Protocol checks for wpcache_top, attached with bind below.
module wpc_chk #(
    parameter int DATA_W = 32,
    parameter int RA_W   = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_slow,
    input logic [DATA_W-1:0] rsp_data,
    input logic              refill_req,
    input logic [RA_W-1:0]   refill_addr,
    input logic              refill_valid
);
    // R4
    slow_is_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_slow) |-> rsp_hit);
    // R4
    slow_after_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_slow) |-> $past(!req_ready));
    // R6
    miss_raises_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (refill_req && !rsp_slow && rsp_data == '0));
    // R7
    fill_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refill_req |-> !req_ready);
    // R7
    fill_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_req && !refill_valid) |=> (refill_req && $stable(refill_addr)));
endmodule

bind wpcache_top wpc_chk #(.DATA_W(DATA_W), .RA_W(ADDR_W - OFF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_slow(rsp_slow),
    .rsp_data(rsp_data), .refill_req(refill_req),
    .refill_addr(refill_addr), .refill_valid(refill_valid)
);

// File: tb/sim_wpcache_top.sv
`timescale 1ns/1ps
module sim_wpcache_top;
    localparam int ADDR_W = 16, SETS = 16, WORDS = 4, DATA_W = 32;
    localparam int OFF_W = 2, RA_W = ADDR_W - OFF_W;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, refill_valid = 0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [WORDS*DATA_W-1:0] refill_data = '0;
    logic req_ready, rsp_valid, rsp_hit, rsp_slow, refill_req;
    logic [DATA_W-1:0] rsp_data;
    logic [RA_W-1:0] refill_addr;

    int total = 0, failed = 0;
    bit mv [2][SETS];
    int mt [2][SETS];
    bit mp [SETS];

    always #2 clk = ~clk;

    wpcache_top u0 (.*);

    function automatic logic [DATA_W-1:0] mem_word(int a);
        return {16'(a) ^ 16'h5A5A, 16'(a)};
    endfunction

    task automatic check(bit ok, string rq, longint act, longint exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    // One read, expectations from the requirement model; serves refills.
    task automatic access(int addr);
        int line = addr >> OFF_W, s = line % SETS, t = line / SETS;
        bit p = mp[s];
        bit hp = mv[p][s] && mt[p][s] == t;
        bit ho = mv[!p][s] && mt[!p][s] == t;
        bit vw;
        req_addr = ADDR_W'(addr); req_valid = 1;
        tick();
        req_valid = 0;
        if (hp) begin
            // R3 fast hit
            check(rsp_valid && rsp_hit && !rsp_slow, "R3 flags", {rsp_valid, rsp_hit, rsp_slow}, 3'b110);
            check(rsp_data == mem_word(addr), "R3 data / R2 split", rsp_data, mem_word(addr));
        end else if (ho) begin
            // R4 slow hit: nothing yet, stalled
            check(!rsp_valid && !req_ready, "R4 stall cycle", {rsp_valid, req_ready}, 0);
            tick();
            check(rsp_valid && rsp_hit && rsp_slow, "R4 flags", {rsp_valid, rsp_hit, rsp_slow}, 3'b111);
            check(rsp_data == mem_word(addr), "R4 data", rsp_data, mem_word(addr));
            mp[s] = !p;  // R5 retrain
        end else begin
            // R6 miss response and refill request
            check(rsp_valid && !rsp_hit && !rsp_slow && rsp_data == 0, "R6 miss rsp",
                  {rsp_valid, rsp_hit, rsp_slow}, 3'b100);
            check(refill_req && refill_addr == RA_W'(line), "R6 refill addr", refill_addr, line);
            // R7 requests ignored while refilling
            req_addr = ADDR_W'(addr ^ 16'h0100); req_valid = 1;
            for (int i = 0; i < 2; i++) begin
                tick();
                check(!rsp_valid && !req_ready && refill_req, "R7 blocked",
                      {rsp_valid, req_ready, refill_req}, 3'b001);
            end
            req_valid = 0;
            // R10 word w at [w*DATA_W +: DATA_W]
            for (int w = 0; w < WORDS; w++)
                refill_data[w*DATA_W +: DATA_W] = mem_word(line * WORDS + w);
            refill_valid = 1;
            tick();
            refill_valid = 0;
            check(!refill_req && req_ready && !rsp_valid, "R7 release",
                  {refill_req, req_ready, rsp_valid}, 3'b010);
            // R8 victim, R9 prediction follows fill
            if (!mv[0][s]) vw = 0;
            else if (!mv[1][s]) vw = 1;
            else vw = !mp[s];
            mv[vw][s] = 1; mt[vw][s] = t; mp[s] = vw;
        end
    endtask

    task automatic t_reset();
        // R1
        check(!rsp_valid && !refill_req && req_ready, "R1 reset outputs",
              {rsp_valid, refill_req, req_ready}, 3'b001);
    endtask

    task automatic t_cold_fill();
        // R8 empty way 0, R9 fast afterwards, R10/R2 every word offset
        access(12);
        for (int w = 12; w < 16; w++) access(w);
    endtask

    task automatic t_mispredict();
        access(76);   // same set, way 1 (R8)
        access(77);   // R9 fast
        access(14);   // R4 slow
        access(15);   // R5 now fast
        access(14);
    endtask

    task automatic t_full_set();
        access(140);  // R8: both valid, unpredicted way replaced
        access(141);
        access(13);   // slow after fill moved prediction
        access(76);   // evicted earlier: miss
        access(77);
        access(12);
    endtask

    task automatic t_other_set();
        access(260);  // R2 different set
        access(263);
        access(12);
    endtask

    initial begin
        #(4 * 100000);
        failed++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        for (int s = 0; s < SETS; s++) begin
            mp[s] = 0; mv[0][s] = 0; mv[1][s] = 0; mt[0][s] = 0; mt[1][s] = 0;
        end
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_cold_fill();
        t_mispredict();
        t_full_set();
        t_other_set();
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule